// File: doc/BRIEF.md
# TDM Audio Serial Transmitter

This block sends parallel audio words out on a single serial line as a time-division frame. It is always the timing master. From the system clock it makes a bit clock, a frame sync and the serial data. Each frame carries a fixed number of words, set at run time. One word is pulled through a valid/ready stream at the first bit slot of every word.

The word length, frame length, bit order, frame-sync polarity, early frame-sync option and bit-clock divider are plain inputs. They must be held steady while the transmitter runs. When a word is due and the stream has none, zeros go out in its slots and a sticky underrun flag is raised. A one-clock word-start pulse marks the first bit of every word.

When the enable input rises, a new frame starts at word 0. When it falls, the current frame is finished first and the line then returns to idle.

Top module: `tdm_tx`

## Requirements
- R1: A word is `wl_m1`+1 bits long. Any `wl_m1` below 7 is treated as 7, so words are 8 to 32 bits.
- R2: A frame is `fl_m1`+1 words long (1 to 32).
- R3: While running, `bclk` has a period of 2·(`div_half_m1`+1) system clocks, so the divide ratio is even, from 2 to 512. Each bit slot begins with a low half. When idle, `bclk` is 0.
- R4: `sdata` and `fsync` change only in the cycle where `bclk` falls, or when a run starts. They are therefore stable at each rising edge of `bclk`, which is where the receiver samples.
- R5: Without the early option, frame sync is active for exactly the first word of each frame. The active level is high when `fs_low`=0 and low when `fs_low`=1. The inactive level is the complement.
- R6: With `fs_early`=1, frame sync is active from the last bit slot of the previous frame through the second-last bit of word 0, which is still one word length. The first frame after enable is preceded by one extra lead slot: frame sync is active there and data is 0.
- R7: With `msb_first`=1, word bit `wl_m1` is sent first and bit 0 last. With `msb_first`=0, bit 0 is sent first.
- R8: `s_ready` is high for one clock at the start of each word slot, and a word is taken only if `s_valid` is high in that clock. Words are sent in the order they are accepted.
- R9: If `s_valid` is low when a word is due, that word is sent as zeros and `underrun` is set. `underrun` stays set until the next start from idle clears it.
- R10: `word_start` pulses for one clock, one cycle after each accepted or missed word fetch, i.e. once per word.
- R11: Clearing `en` stops the transmitter only after the last bit of the current frame. Afterwards `bclk` and `sdata` are 0 and `fsync` is at its inactive level.
- R12: After reset, `bclk`, `sdata`, `s_ready`, `word_start` and `underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Transmitter enable |
| wl_m1 | input | 5 | Word length minus one |
| fl_m1 | input | 5 | Words per frame minus one |
| msb_first | input | 1 | 1: most significant bit first |
| fs_low | input | 1 | 1: frame sync active low |
| fs_early | input | 1 | 1: frame sync leads the frame by one bit |
| div_half_m1 | input | 8 | Bit-clock ratio / 2 − 1 |
| s_data | input | 32 | Word to send, right-aligned |
| s_valid | input | 1 | Word available |
| s_ready | output | 1 | Word taken this clock |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| word_start | output | 1 | First bit of a word launched |
| underrun | output | 1 | Sticky: a word was missing |

## Verification
The hardest case to reach from the ports is a disable that lands mid-frame while the stream is also running dry. In that case the zero-filled words, the sticky flag and the frame-boundary stop all interact. The bench supplies a limited number of words per run. It drops `en` just after the first bit of the final frame is sampled. It then counts every rising edge of the bit clock, to prove that exactly whole frames, plus the lead slot in early mode, were emitted. Random configurations cover word and frame sizes, divider values, polarity, bit order and early timing. Directed runs cover the I2S-like setting, the clamped word length and the largest divider.

// File: rtl/tdm_tx.sv
module tdm_tx #(
  parameter int MAXW = 32,
  parameter int DIVW = 8,
  parameter int IW   = $clog2(MAXW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [IW-1:0]   wl_m1,
  input  logic [IW-1:0]   fl_m1,
  input  logic            msb_first,
  input  logic            fs_low,
  input  logic            fs_early,
  input  logic [DIVW-1:0] div_half_m1,
  input  logic [MAXW-1:0] s_data,
  input  logic            s_valid,
  output logic            s_ready,
  output logic            bclk,
  output logic            fsync,
  output logic            sdata,
  output logic            word_start,
  output logic            underrun
);
  localparam logic [IW-1:0] MINW = IW'(7);

  logic            run, bclk_q, sd_q, fs_q, ws_q, ur_q;
  logic [DIVW-1:0] dcnt;
  logic [IW-1:0]   bit_i, word_i;
  logic [MAXW-1:0] sh;

  logic [IW-1:0]   wl, bsel;
  logic [MAXW-1:0] cw;
  logic            start, tick, fall, stop, lead, emit, first, fs_slot, last_bit;

  assign wl       = (wl_m1 < MINW) ? MINW : wl_m1;
  assign start    = !run && en;
  assign tick     = run && (dcnt == div_half_m1);
  assign fall     = tick && bclk_q;
  assign stop     = fall && (bit_i == '0) && (word_i == '0) && !en;
  assign lead     = start && fs_early;
  assign emit     = (start && !fs_early) || (fall && !stop);
  assign first    = emit && (bit_i == '0);
  assign last_bit = (bit_i == wl);
  assign cw       = (bit_i == '0) ? (s_valid ? s_data : '0) : sh;
  assign bsel     = msb_first ? (wl - bit_i) : bit_i;
  assign fs_slot  = fs_early ? (((word_i == '0) && !last_bit) || ((word_i == fl_m1) && last_bit))
                             : (word_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; bclk_q <= 1'b0; sd_q <= 1'b0; fs_q <= 1'b0;
      ws_q <= 1'b0; ur_q <= 1'b0; dcnt <= '0; bit_i <= '0; word_i <= '0; sh <= '0;
    end else begin
      ws_q <= first;
      if (start) begin
        run <= 1'b1; dcnt <= '0; bclk_q <= 1'b0; ur_q <= 1'b0;
      end else if (run) begin
        if (tick) begin
          dcnt <= '0;
          bclk_q <= !bclk_q;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
      if (stop) begin
        run <= 1'b0; bclk_q <= 1'b0; sd_q <= 1'b0; fs_q <= 1'b0;
      end
      if (lead) begin
        sd_q <= 1'b0; fs_q <= 1'b1;
      end
      if (emit) begin
        sd_q <= cw[bsel];
        fs_q <= fs_slot;
        if (bit_i == '0) sh <= cw;
        if (first && !s_valid) ur_q <= 1'b1;
        if (last_bit) begin
          bit_i  <= '0;
          word_i <= (word_i == fl_m1) ? '0 : word_i + 1'b1;
        end else begin
          bit_i <= bit_i + 1'b1;
        end
      end
    end
  end

  assign s_ready    = first;
  assign bclk       = bclk_q;
  assign sdata      = sd_q;
  assign fsync      = fs_q ^ fs_low;
  assign word_start = ws_q;
  assign underrun   = ur_q;

  assert_idle_bclk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !bclk_q);
  assert_launch_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_q |=> ($stable(sd_q) && $stable(fs_q)) || !bclk_q);
  assert_ready_then_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> word_start);
  assert_ready_only_running_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (run || en));
  assert_sticky_underrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ur_q && run) |=> ur_q);
  assert_stop_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> (bit_i == '0) && (word_i == '0));
endmodule

// File: tb/sim_tdm_tx.sv
module sim_tdm_tx;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [4:0] wl_m1 = 5'd7, fl_m1 = 5'd0;
  logic msb_first = 1'b1, fs_low = 1'b0, fs_early = 1'b0;
  logic [7:0] div_half_m1 = 8'd0;
  logic [31:0] s_data;
  logic s_valid, s_ready, bclk, fsync, sdata, word_start, underrun;

  always #2 clk = ~clk;

  tdm_tx u0 (.clk(clk), .rst_n(rst_n), .en(en), .wl_m1(wl_m1), .fl_m1(fl_m1),
    .msb_first(msb_first), .fs_low(fs_low), .fs_early(fs_early), .div_half_m1(div_half_m1),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready), .bclk(bclk), .fsync(fsync),
    .sdata(sdata), .word_start(word_start), .underrun(underrun));

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] words [0:1023];
  int widx = 0, avail = 0;
  logic feed = 1'b0;
  assign s_valid = feed && (widx < avail);
  assign s_data  = words[widx[9:0]];

  always @(posedge clk) if (s_valid && s_ready) widx <= widx + 1;

  logic cap_sd [0:2047];
  logic cap_fs [0:2047];
  int ncap = 0, nws = 0, per_err = 0, last_rise = -1, ratio = 2;
  logic prev_b = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (word_start) nws <= nws + 1;
    if (bclk && !prev_b) begin
      if (ncap < 2048) begin cap_sd[ncap] <= sdata; cap_fs[ncap] <= fsync; end
      ncap <= ncap + 1;
      if (last_rise >= 0 && (cyc - last_rise) != ratio) per_err <= per_err + 1;
      last_rise <= cyc;
    end
    prev_b <= bclk;
  end

  always @(posedge clk) if (cyc > 190000) begin
    fails = fails + 1;
    $display("FAIL watchdog expired: actual %0d cycles, expected under 190000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_fs(int j, int W, int F, bit early);
    int bpf = W * F;
    int s;
    if (early && j == 0) return 1'b1;
    s = (j - (early ? 1 : 0)) % bpf;
    return early ? (s < W - 1 || s == bpf - 1) : (s < W);
  endfunction

  function automatic bit exp_sd(int j, int W, int F, bit early, bit msb, int av);
    int bpf = W * F;
    int jj, f, s, k, b;
    logic [31:0] d;
    if (early && j == 0) return 1'b0;
    jj = j - (early ? 1 : 0);
    f = jj / bpf; s = jj % bpf; b = s % W;
    k = f * F + s / W;
    d = (k < av) ? words[k] : 32'd0;
    return msb ? d[W-1-b] : d[b];
  endfunction

  task automatic run_case(input int wlm, input int flm, input bit msb, input bit low,
                          input bit early, input int dv, input int av, input int frames);
    int W = (wlm < 7) ? 8 : wlm + 1;
    int F = flm + 1;
    int lead = early ? 1 : 0;
    int total = lead + frames * W * F;
    int bad_sd = 0, bad_fs = 0;
    int need = F * frames;
    for (int i = 0; i < 1024; i++) words[i] = $urandom;
    @(negedge clk);
    wl_m1 = 5'(wlm); fl_m1 = 5'(flm); msb_first = msb; fs_low = low; fs_early = early;
    div_half_m1 = 8'(dv); ratio = 2 * (dv + 1); avail = av;
    @(negedge clk);
    widx = 0; ncap = 0; nws = 0; per_err = 0; last_rise = -1;
    feed = 1'b1; en = 1'b1;
    while (ncap < lead + (frames - 1) * W * F + 1) @(negedge clk);
    en = 1'b0;
    repeat ((W * F + 4) * ratio + 20) @(negedge clk);
    feed = 1'b0;
    check(ncap == total, "R11 R2 R1 frame-boundary stop edge count", ncap, total);
    for (int j = 0; j < total && j < ncap && j < 2048; j++) begin
      if (cap_sd[j] !== exp_sd(j, W, F, early, msb, av)) bad_sd++;
      if (cap_fs[j] !== (exp_fs(j, W, F, early) ^ low)) bad_fs++;
    end
    check(bad_sd == 0, "R7 R4 R1 data bits", bad_sd, 0);
    check(bad_fs == 0, early ? "R6 frame sync early" : "R5 frame sync", bad_fs, 0);
    check(per_err == 0, "R3 bit clock period", per_err, 0);
    check(nws == need, "R10 word_start pulses", nws, need);
    check(widx == ((av < need) ? av : need), "R8 words accepted", widx, (av < need) ? av : need);
    check(underrun == (av < need), "R9 underrun flag", underrun, av < need);
    check(bclk == 1'b0 && sdata == 1'b0 && fsync == low, "R11 idle levels",
          {bclk, sdata, fsync}, {2'b00, low});
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check(bclk == 0 && sdata == 0 && s_ready == 0 && word_start == 0 && underrun == 0,
          "R12 reset state", {bclk, sdata, s_ready, word_start, underrun}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case(15, 1, 1, 1, 1, 1, 1000, 3);
    run_case(7, 0, 0, 0, 0, 0, 1000, 4);
    run_case(31, 3, 1, 0, 1, 2, 1000, 2);
    run_case(3, 2, 1, 0, 0, 0, 1000, 2);
    run_case(11, 3, 0, 1, 0, 1, 5, 3);
    run_case(9, 1, 1, 0, 0, 0, 1000, 2);
    run_case(7, 0, 1, 0, 1, 0, 1000, 3);
    run_case(7, 0, 1, 0, 0, 255, 1000, 1);
    for (int t = 0; t < 12; t++)
      run_case(7 + $urandom_range(0, 24), $urandom_range(0, 7), 1'($urandom), 1'($urandom),
               1'($urandom), $urandom_range(0, 3),
               ($urandom_range(0, 3) == 0) ? $urandom_range(0, 6) : 1000, 2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule